// File: doc/BRIEF.md
# SDRAM Burst Column Address Sequencer

This block produces the column address for every beat of an SDRAM burst. A controller gives it a start column together with the burst-length code and the burst-type bit from the mode register. The block presents beat 0 in the same cycle as the start pulse, and then one further beat on each following clock. It raises a flag on the final beat of a fixed-length burst.

Two wrap orderings are supported. Sequential ordering counts upward inside the aligned block. Interleaved ordering XORs the beat number into the low address bits. A full-page setting walks the whole row modulo 2048 columns and runs until the controller terminates it.

The mode fields are captured at start, so the controller may change them while a burst is running. A terminate input cuts a burst short on the next clock. A start carrying a reserved mode code raises an error flag, produces no address, and cancels any burst in progress.

Top module: `burst_col_seq`

## Requirements
- R1: Burst-length code 3'b000, 3'b001, 3'b010 and 3'b011 gives 1, 2, 4 and 8 beats. `last_beat` is high on the final beat only, and `col_valid` is low on the cycle after it unless a new start arrives.
- R2: In the cycle where `start` is high with a legal mode, `col_valid` is high and `col_addr` equals `start_col`. Each later beat follows on the next clock with no gaps.
- R3: With `mode_bt`=0 (sequential), the low log2(BL) bits of beat n equal (start low bits + n) mod BL, and the upper bits equal those of `start_col`.
- R4: With `mode_bt`=1 (interleaved), the low log2(BL) bits of beat n equal the start low bits XOR n, and the upper bits equal those of `start_col`.
- R5: Code 3'b111 with `mode_bt`=0 selects full page. Beat n is (`start_col` + n) mod 2048, `last_beat` never rises, and the burst continues until terminated.
- R6: A start with code 3'b100, 3'b101 or 3'b110, or with 3'b111 while `mode_bt`=1, is reserved. It drives `mode_err` high in that cycle and keeps `col_valid` low. It also stops any running burst, so `col_valid` is low on the next cycle.
- R7: When `term` is high during a valid beat, that beat is still presented, and `col_valid` is low on the next cycle. This also applies when `term` arrives in the start cycle.
- R8: A legal `start` during a running burst abandons the old burst. It begins the new sequence from the new `start_col` in that same cycle.
- R9: Changes to `mode_bl`, `mode_bt` and `start_col` while `start` is low have no effect on a running burst.
- R10: After reset, `col_valid`, `last_beat` and `mode_err` are low and `col_addr` is 0. `col_addr` reads 0 whenever `col_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a burst with the current mode and start column |
| start_col | input | 11 | Column of beat 0 |
| mode_bl | input | 3 | Burst-length code from the mode register |
| mode_bt | input | 1 | Burst type: 0 sequential, 1 interleaved |
| term | input | 1 | End the burst after the current beat |
| col_addr | output | 11 | Column address of the current beat, 0 when idle |
| col_valid | output | 1 | A beat is presented this cycle |
| last_beat | output | 1 | The current beat is the final one of a fixed-length burst |
| mode_err | output | 1 | Start was given with a reserved mode code |

## Verification
Every fixed burst length is run in both orderings from all eight low start offsets. This is done under two different upper-bit patterns, which separates block wrap from a plain increment and shows that the upper bits are held. During each burst the mode and column inputs are scrambled, which shows that the captured mode governs the burst. A full-page run that crosses column 2047 separates modulo-row wrap from block wrap. Further directed runs cover termination (mid-burst and in the start cycle), restart during a burst, and every reserved code, including a reserved start arriving mid-burst.

// File: rtl/bcs_pkg.sv
// Shared types for the burst column sequencer.
// Assumes the mode fields use a 3-bit length code and a 1-bit type bit.
package bcs_pkg;

    localparam int BL_CODE_W = 3;
    localparam int LG_W      = 2;

    typedef struct packed {
        logic            ok;    // legal mode
        logic            full;  // full-page burst
        logic            ilv;   // interleaved ordering
        logic [LG_W-1:0] lg;    // log2 of fixed burst length
    } mode_t;

    // Turn the raw mode fields into a decoded burst description.
    function automatic mode_t decode_mode(input logic [BL_CODE_W-1:0] code,
                                          input logic bt);
        mode_t m;
        m.ilv  = bt;
        m.full = (code == 3'b111) && !bt;
        m.ok   = (code[2] == 1'b0) || m.full;
        m.lg   = code[2] ? '0 : code[LG_W-1:0];
        return m;
    endfunction

endpackage

// File: rtl/bcs_mode_decode.sv
// Mode decoder: maps the burst-length code and burst-type bit onto a
// decoded burst description. Purely combinational; assumes nothing about timing.
module bcs_mode_decode
    import bcs_pkg::*;
(
    input  logic [BL_CODE_W-1:0] code,
    input  logic                 bt,
    output mode_t                dec
);

    // Decode the live mode fields.
    always_comb dec = decode_mode(code, bt);

endmodule

// File: rtl/bcs_beat_ctr.sv
// Beat counter: captures mode and start column at start, counts beats,
// marks the last beat and handles termination and restart.
// Assumes start has priority over any running burst.
module bcs_beat_ctr
    import bcs_pkg::*;
#(
    parameter int COL_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             term,
    input  logic [COL_W-1:0] base_in,
    input  mode_t            dec,
    output mode_t            cur_mode,
    output logic [COL_W-1:0] cur_base,
    output logic [COL_W-1:0] cur_beat,
    output logic             valid,
    output logic             last,
    output logic             err
);

    logic             active_q;
    mode_t            mode_q;
    logic [COL_W-1:0] base_q;
    logic [COL_W-1:0] beat_q;
    logic [COL_W-1:0] last_idx;

    // Select live inputs in the start cycle, captured state otherwise.
    always_comb begin
        cur_mode = start ? dec     : mode_q;
        cur_base = start ? base_in : base_q;
        cur_beat = start ? '0      : beat_q;
        valid    = start ? dec.ok  : active_q;
        err      = start & ~dec.ok;
        last_idx = (COL_W'(1) << cur_mode.lg) - COL_W'(1);
        last     = valid & ~cur_mode.full & (cur_beat == last_idx);
    end

    // Capture the burst on start and advance one beat per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            mode_q   <= '0;
            base_q   <= '0;
            beat_q   <= '0;
        end else if (start) begin
            mode_q   <= dec;
            base_q   <= base_in;
            beat_q   <= COL_W'(1);
            active_q <= dec.ok & ~last & ~term;
        end else if (active_q) begin
            beat_q <= beat_q + COL_W'(1);
            if (last || term) active_q <= 1'b0;
        end
    end

    // R1: after the final beat no beat follows unless restarted.
    assert_last_ends_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && last) |=> (!valid || start));

    // R1: a fixed-length burst never counts past its final beat.
    assert_beat_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && !mode_q.full) |->
        (beat_q <= ((COL_W'(1) << mode_q.lg) - COL_W'(1))));

    // R7: terminate ends the burst on the next clock.
    assert_term_stops_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && term) |=> (!valid || start));

    // R6: a reserved start produces no beat now or next cycle.
    assert_err_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !valid);
    assert_err_cancels_R6: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> (!valid || start));

endmodule

// File: rtl/bcs_addr_gen.sv
// Address generator: forms the column of the current beat from the base
// column, beat index and decoded mode. Assumes beat < BL for fixed bursts.
module bcs_addr_gen
    import bcs_pkg::*;
#(
    parameter int COL_W = 11
) (
    input  logic [COL_W-1:0] base,
    input  logic [COL_W-1:0] beat,
    input  mode_t            mode,
    output logic [COL_W-1:0] mask,
    output logic [COL_W-1:0] addr
);

    logic [COL_W-1:0] seq_v;
    logic [COL_W-1:0] ilv_v;

    // Per-bit wrap mask: low lg bits for fixed bursts, every bit for full page.
    for (genvar i = 0; i < COL_W; i++) begin : g_mask
        assign mask[i] = mode.full | (i < int'(mode.lg));
    end

    // Merge the held upper bits with the ordered low bits.
    always_comb begin
        seq_v = base + beat;
        ilv_v = base ^ beat;
        addr  = (base & ~mask) | ((mode.ilv ? ilv_v : seq_v) & mask);
    end

endmodule

// File: rtl/burst_col_seq.sv
// Top level of the burst column sequencer. Decodes the mode, counts beats
// and orders column addresses. Assumes a legal start may arrive at any time.
module burst_col_seq
    import bcs_pkg::*;
#(
    parameter int COL_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [COL_W-1:0] start_col,
    input  logic [2:0]       mode_bl,
    input  logic             mode_bt,
    input  logic             term,
    output logic [COL_W-1:0] col_addr,
    output logic             col_valid,
    output logic             last_beat,
    output logic             mode_err
);

    mode_t            dec;
    mode_t            cur_mode;
    logic [COL_W-1:0] cur_base;
    logic [COL_W-1:0] cur_beat;
    logic [COL_W-1:0] mask;
    logic [COL_W-1:0] gen_addr;

    bcs_mode_decode u_dec (
        .code (mode_bl),
        .bt   (mode_bt),
        .dec  (dec)
    );

    bcs_beat_ctr #(.COL_W(COL_W)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .term     (term),
        .base_in  (start_col),
        .dec      (dec),
        .cur_mode (cur_mode),
        .cur_base (cur_base),
        .cur_beat (cur_beat),
        .valid    (col_valid),
        .last     (last_beat),
        .err      (mode_err)
    );

    bcs_addr_gen #(.COL_W(COL_W)) u_gen (
        .base (cur_base),
        .beat (cur_beat),
        .mode (cur_mode),
        .mask (mask),
        .addr (gen_addr)
    );

    // Drive zero on the address bus between bursts.
    always_comb col_addr = col_valid ? gen_addr : '0;

    // R3: sequential beats step by one inside the wrap field.
    assert_seq_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid && !start && !cur_mode.ilv) |->
        (((col_addr - $past(col_addr)) & mask) == COL_W'(1)));

    // R4: interleaved beats keep the bits above the wrap field.
    assert_upper_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid && !start && cur_mode.ilv) |->
        (((col_addr ^ $past(col_addr)) & ~mask) == '0));

    // R5: a full-page burst never flags a last beat.
    assert_fullpage_nolast_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid && cur_mode.full) |-> !last_beat);

    // R10: idle bus reads zero.
    assert_idle_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !col_valid |-> (col_addr == '0));

endmodule

// File: tb/sim_burst_col_seq.sv
// Directed bench for the burst column sequencer; one task per scenario.
module sim_burst_col_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [10:0] start_col = '0;
    logic [2:0]  mode_bl = '0;
    logic        mode_bt = 1'b0;
    logic        term = 1'b0;
    logic [10:0] col_addr;
    logic        col_valid, last_beat, mode_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    burst_col_seq u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
        .mode_bl(mode_bl), .mode_bt(mode_bt), .term(term),
        .col_addr(col_addr), .col_valid(col_valid),
        .last_beat(last_beat), .mode_err(mode_err)
    );

    function automatic int ref_addr(int code, int bt, int s, int n);
        int bl, lo, blk;
        if (code == 7) return (s + n) % 2048;
        bl  = 1 << code;
        lo  = s % bl;
        blk = s - lo;
        return bt ? blk + (lo ^ n) : blk + ((lo + n) % bl);
    endfunction

    task automatic drive(bit st, int code, bit bt, int col, bit tm);
        @(negedge clk);
        start = st; mode_bl = 3'(code); mode_bt = bt;
        start_col = 11'(col); term = tm;
        #1;
    endtask

    task automatic expect_out(bit v, int a, bit l, bit e, string tag);
        checks++;
        if (col_valid !== v || int'(col_addr) != a || last_beat !== l || mode_err !== e) begin
            fails++;
            $display("FAIL %s: valid/addr/last/err = %0d/%0d/%0d/%0d expected %0d/%0d/%0d/%0d",
                     tag, col_valid, col_addr, last_beat, mode_err, v, a, l, e);
        end
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        drive(0, 0, 0, 0, 0);
        expect_out(0, 0, 0, 0, "R10 reset");
        rst_n = 1'b1;
        drive(0, 0, 0, 0, 0);
        expect_out(0, 0, 0, 0, "R10 idle");
    endtask

    // Fixed burst with scrambled mode inputs after the start cycle (R9).
    task automatic fixed_burst(int code, bit bt, int scol);
        int bl = 1 << code;
        string tag = bt ? "R1/R2/R4/R9" : "R1/R2/R3/R9";
        for (int n = 0; n < bl; n++) begin
            if (n == 0) drive(1, code, bt, scol, 0);
            else        drive(0, code ^ 5, ~bt, scol ^ 11'h3FF, 0);
            expect_out(1, ref_addr(code, bt, scol, n), n == bl - 1, 0, tag);
        end
        drive(0, 0, 0, 0, 0);
        expect_out(0, 0, 0, 0, "R1 end");
    endtask

    task automatic test_all_fixed();
        for (int code = 0; code < 4; code++)
            for (int bt = 0; bt < 2; bt++)
                for (int off = 0; off < 8; off++) begin
                    fixed_burst(code, bit'(bt), 'h5A8 | off);
                    fixed_burst(code, bit'(bt), 'h7F8 | off);
                end
    endtask

    task automatic test_full_page();
        for (int n = 0; n < 10; n++) begin
            drive(n == 0, 7, 0, 2045, n == 9);
            expect_out(1, (2045 + n) % 2048, 0, 0, "R5 full page");
        end
        drive(0, 0, 0, 0, 0);
        expect_out(0, 0, 0, 0, "R7 full page term");
    endtask

    task automatic test_term();
        for (int n = 0; n < 3; n++) begin
            drive(n == 0, 3, 1, 3, n == 2);
            expect_out(1, ref_addr(3, 1, 3, n), 0, 0, "R7 mid");
        end
        drive(0, 0, 0, 0, 0);
        expect_out(0, 0, 0, 0, "R7 stop");
        drive(1, 2, 0, 9, 1);
        expect_out(1, 9, 0, 0, "R7 start term");
        drive(0, 0, 0, 0, 0);
        expect_out(0, 0, 0, 0, "R7 start term stop");
    endtask

    task automatic test_restart();
        for (int n = 0; n < 3; n++) begin
            drive(n == 0, 3, 0, 'h10D, 0);
            expect_out(1, ref_addr(3, 0, 'h10D, n), 0, 0, "R8 first");
        end
        for (int n = 0; n < 4; n++) begin
            drive(n == 0, 2, 1, 'h0A2, 0);
            expect_out(1, ref_addr(2, 1, 'h0A2, n), n == 3, 0, "R8 second");
        end
        drive(0, 0, 0, 0, 0);
        expect_out(0, 0, 0, 0, "R8 end");
    endtask

    task automatic test_reserved();
        for (int code = 4; code < 8; code++)
            for (int bt = 0; bt < 2; bt++) begin
                if (code == 7 && bt == 0) continue;
                drive(1, code, bit'(bt), 'h123, 0);
                expect_out(0, 0, 0, 1, "R6 reserved");
                drive(0, 0, 0, 0, 0);
                expect_out(0, 0, 0, 0, "R6 after");
            end
        drive(1, 3, 0, 'h100, 0);
        expect_out(1, 'h100, 0, 0, "R6 pre");
        drive(0, 0, 0, 0, 0);
        expect_out(1, 'h101, 0, 0, "R6 pre");
        drive(1, 5, 0, 'h200, 0);
        expect_out(0, 0, 0, 1, "R6 abort");
        drive(0, 0, 0, 0, 0);
        expect_out(0, 0, 0, 0, "R6 abort stop");
    endtask

    initial begin
        test_reset();
        test_all_fixed();
        test_full_page();
        test_term();
        test_restart();
        test_reserved();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule